// File: doc/BRIEF.md
# Filtered Branch History Ring

This block keeps a rolling record of recently retired branches for a performance-monitoring unit. Each retired branch is presented as an event. The event carries three things: the address of the branch instruction, an optional target address, and a one-hot type vector. A type filter, set by software through a small control write, decides which events are kept. Kept events are written into a circular array of 64-bit entries.

Some branches take their target from a register. For those, the block writes two consecutive entries. The first holds the branch address. The second holds the target address, with bit 1 forced high as a tag. The pair takes two cycles, and the block lowers `ev_ready` during the second one. Software reads any entry by index through a combinational port, and it can also see the write pointer.

Top module: `brh_ring`

## Requirements
- R1: Synchronous active-low reset clears the write pointer, the filter mask and every entry to zero, and `ev_ready` is high after reset. With the reset mask, no event is stored until a control write enables recording.
- R2: When a control write has `ctl_enable` = 0, the filter stores nothing, whatever the type or mode.
- R3: With `ctl_enable` = 1 and `ctl_mode` = 0, any event whose type vector is nonzero is stored.
- R4: With `ctl_mode` = 1, only events with the call bit (bit 0, value 0x01) set are stored.
- R5: With `ctl_mode` = 2, only events with the indirect bit (bit 1, value 0x02) set are stored.
- R6: With `ctl_mode` = 3, only events with the conditional bit (bit 2, value 0x04) set are stored. The other bit (bit 3, 0x08) never matches a single-class mode.
- R7: An event with type vector 0 is never stored and leaves the pointer unchanged.
- R8: A stored event with the register-target bit (bit 4, 0x10) set writes two entries. The first holds the branch address. The next one holds the target address with bit 1 set. `ev_ready` is low in the cycle after acceptance and high again one cycle later.
- R9: The write pointer advances by one per written entry and wraps from 31 to 0, overwriting the oldest entry.
- R10: `rd_data` shows the entry at `rd_idx` combinationally. A read in the same cycle as a write to that entry returns the old value.
- R11: A control write updates the mask at the clock edge. An event accepted in the same cycle is filtered with the previous mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe; reloads the filter mask |
| ctl_enable | input | 1 | Monitor enable carried by the control write |
| ctl_mode | input | 2 | Filter mode: 0 all, 1 call, 2 indirect, 3 conditional |
| ev_valid | input | 1 | Branch event present |
| ev_ready | output | 1 | Block can accept an event this cycle |
| ev_pc | input | 64 | Branch instruction address |
| ev_tgt | input | 64 | Branch target address (used for register-target form) |
| ev_kind | input | 5 | One-hot-ish branch type vector |
| rd_idx | input | 5 | Entry index to read |
| rd_data | output | 64 | Entry contents at rd_idx |
| wr_ptr | output | 5 | Index of the next entry to be written |

## Verification
The bench targets the corner cases below, and each one exposes a specific design fault.
- The register-target pair. A design that skips the tag bit, or drops the second write, leaves a wrong or stale entry behind the branch address. A design that lets a new event slip in would corrupt the pair, so the bench also checks that `ev_ready` falls for exactly one cycle.
- Filter mode cross-checks. Each mode gets an event that should match and one that should not. A mis-decoded mode stores the wrong class or nothing at all.
- Enable and zero-type cases. A filter that ignores enable, or a zero type that slips through, shows up as a pointer that moves.
- Same-cycle ordering. The bench issues a control write alongside an event, and a read alongside a write. A mask that acts too early, or a read port that sees the new data, shows up in the compared values.
- Pointer wrap. The bench writes past entry 31. A pointer that does not wrap, or wraps to the wrong place, misses the overwritten oldest entry.

// File: rtl/brh_pkg.sv
// Shared type encodings and widths for the branch history ring.
// Assumes event type vectors are 5 bits wide with the bit meanings below.
package brh_pkg;
    localparam int KIND_W = 5;
    typedef logic [KIND_W-1:0] kind_t;

    localparam kind_t KIND_NONE  = 5'h00;
    localparam kind_t KIND_CALL  = 5'h01;
    localparam kind_t KIND_IND   = 5'h02;
    localparam kind_t KIND_COND  = 5'h04;
    localparam kind_t KIND_OTHER = 5'h08;
    localparam kind_t KIND_XL    = 5'h10;
    localparam int    XL_BIT     = 4;

    typedef enum logic [1:0] {
        MODE_ALL  = 2'd0,
        MODE_CALL = 2'd1,
        MODE_IND  = 2'd2,
        MODE_COND = 2'd3
    } mode_e;
endpackage

// File: rtl/brh_filter.sv
// Filter mask register. Turns the monitor enable and the 2-bit mode into a
// type mask, reloaded only on a control write strobe.
// Assumes: the mask takes effect from the cycle after the write.
module brh_filter
    import brh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       ctl_enable,
    input  logic [1:0] ctl_mode,
    output kind_t      mask_q
);
    kind_t mask_d;

    // Decode the requested mask from enable and mode.
    always_comb begin
        if (!ctl_enable) begin
            mask_d = KIND_NONE;
        end else begin
            case (mode_e'(ctl_mode))
                MODE_ALL:  mask_d = '1;
                MODE_CALL: mask_d = KIND_CALL;
                MODE_IND:  mask_d = KIND_IND;
                default:   mask_d = KIND_COND;
            endcase
        end
    end

    // Hold the mask; reset clears it, a control write reloads it.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= KIND_NONE;
        else if (ctl_wr) mask_q <= mask_d;
    end
endmodule

// File: rtl/brh_seq.sv
// Write sequencer. Accepts one event per ready cycle, tests it against the
// mask and issues one or two entry writes at the write pointer.
// Assumes: the second write of a pair blocks new events for one cycle.
module brh_seq
    import brh_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [DATA_W-1:0] ev_pc,
    input  logic [DATA_W-1:0] ev_tgt,
    input  kind_t             ev_kind,
    input  kind_t             mask,
    output logic              ev_ready,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [DATA_W-1:0] TGT_TAG = DATA_W'(2);

    logic              pend_q;
    logic [DATA_W-1:0] tgt_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              hit;

    // An accepted event is kept when its type overlaps the mask.
    always_comb begin
        hit      = ev_valid && !pend_q && ((ev_kind & mask) != '0);
        ev_ready = !pend_q;
        we       = pend_q || hit;
        waddr    = ptr_q;
        wdata    = pend_q ? tgt_q : ev_pc;
        ptr      = ptr_q;
    end

    // Advance the pointer per write and track a pending target write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            pend_q <= 1'b0;
            tgt_q  <= '0;
        end else begin
            if (we) ptr_q <= ptr_q + ADDR_W'(1);
            if (pend_q) begin
                pend_q <= 1'b0;
            end else if (hit && ev_kind[XL_BIT]) begin
                pend_q <= 1'b1;
                tgt_q  <= ev_tgt | TGT_TAG;
            end
        end
    end
endmodule

// File: rtl/brh_store.sv
// Entry array: DEPTH registers of DATA_W bits, one write port, one
// combinational read port. Assumes: a same-cycle read sees the old value.
module brh_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Each entry clears on reset and loads when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  ent_q[i] <= '0;
            else if (we && (waddr == ADDR_W'(i)))         ent_q[i] <= wdata;
        end
    end

    // Read port: plain index into the entries.
    always_comb rdata = ent_q[raddr];
endmodule

// File: rtl/brh_ring.sv
// Top of the filtered branch history ring: filter mask, write sequencer and
// entry array. Assumes the producer holds events while ev_ready is low.
module brh_ring
    import brh_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_enable,
    input  logic [1:0]        ctl_mode,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [DATA_W-1:0] ev_pc,
    input  logic [DATA_W-1:0] ev_tgt,
    input  logic [KIND_W-1:0] ev_kind,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] wr_ptr
);
    kind_t             filt_mask;
    logic              st_we;
    logic [ADDR_W-1:0] st_waddr;
    logic [DATA_W-1:0] st_wdata;

    brh_filter u_filter (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
        .ctl_enable(ctl_enable), .ctl_mode(ctl_mode), .mask_q(filt_mask)
    );

    brh_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_pc(ev_pc),
        .ev_tgt(ev_tgt), .ev_kind(ev_kind), .mask(filt_mask),
        .ev_ready(ev_ready), .we(st_we), .waddr(st_waddr),
        .wdata(st_wdata), .ptr(wr_ptr)
    );

    brh_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(st_waddr),
        .wdata(st_wdata), .raddr(rd_idx), .rdata(rd_data)
    );
endmodule

// File: rtl/brh_ring_chk.sv
// Checker for brh_ring: handshake around paired writes, pointer stepping,
// reset state and disabled filtering. Bound to every brh_ring instance.
module brh_ring_chk #(
    parameter int ADDR_W = 5,
    parameter int KW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [KW-1:0]     ev_kind,
    input logic [KW-1:0]     mask,
    input logic [ADDR_W-1:0] wr_ptr
);
    // R8: an accepted register-target event blocks the next cycle.
    a_r8_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && ((ev_kind & mask) != '0) && ev_kind[KW-1])
        |=> !ev_ready);

    // R8: the block is never busy for two cycles in a row.
    a_r8_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_ready |=> ev_ready);

    // R9: the pointer holds or steps by exactly one (with wrap).
    a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wr_ptr == $past(wr_ptr)) ||
                 (wr_ptr == $past(wr_ptr) + ADDR_W'(1)));

    // R2: an empty mask with no pending write leaves the pointer alone.
    a_r2_empty_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0 && ev_ready) |=> $stable(wr_ptr));

    // R1: reset clears pointer and mask and frees the event port.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (wr_ptr == '0 && mask == '0 && ev_ready));
endmodule

bind brh_ring brh_ring_chk #(.ADDR_W(ADDR_W), .KW(brh_pkg::KIND_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .mask(filt_mask), .wr_ptr(wr_ptr)
);

// File: tb/tb_brh_ring.sv
module tb_brh_ring;
    localparam int DEPTH = 32;
    localparam int DW    = 64;
    localparam int AW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0, ctl_enable = 1'b0;
    logic [1:0]    ctl_mode = 2'd0;
    logic          ev_valid = 1'b0;
    logic          ev_ready;
    logic [DW-1:0] ev_pc = '0, ev_tgt = '0;
    logic [4:0]    ev_kind = '0;
    logic [AW-1:0] rd_idx = '0;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] wr_ptr;

    brh_ring dut (.*);

    always #5 clk = ~clk;

    int n_cmp = 0, n_bad = 0;

    // Reference model state
    logic [DW-1:0] mem_m [DEPTH];
    int            ptr_m = 0;
    logic [4:0]    mask_m = '0;
    int            q_idx[$];
    logic [DW-1:0] q_val[$];

    task automatic cmp(string rq, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Driver side of control: issues a control write and updates the model.
    task automatic set_ctl(logic en, logic [1:0] md);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_enable = en; ctl_mode = md;
        @(negedge clk);
        ctl_wr = 1'b0;
        mask_m = !en ? 5'h00 : (md == 0) ? 5'h1F : (md == 1) ? 5'h01 :
                 (md == 2) ? 5'h02 : 5'h04;
    endtask

    // Monitor side: pop expected writes and compare entries and pointer.
    task automatic drain(string rq);
        while (q_idx.size() > 0) begin
            int            i = q_idx.pop_front();
            logic [DW-1:0] v = q_val.pop_front();
            rd_idx = AW'(i);
            #1 cmp(rq, rd_data, v);
        end
        rd_idx = AW'(ptr_m);
        #1 cmp(rq, rd_data, mem_m[ptr_m]);
        cmp(rq, DW'(wr_ptr), DW'(ptr_m));
    endtask

    function automatic void push(logic [DW-1:0] v);
        q_idx.push_back(ptr_m);
        q_val.push_back(v);
        mem_m[ptr_m] = v;
        ptr_m = (ptr_m + 1) % DEPTH;
    endfunction

    // Driver: presents one event and pushes the expected entries.
    task automatic send(logic [4:0] k, logic [DW-1:0] pc, logic [DW-1:0] tg, string rq);
        logic hit, xl;
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = k; ev_pc = pc; ev_tgt = tg;
        hit = (k & mask_m) != 0;
        xl  = hit && k[4];
        if (hit) push(pc);
        if (xl)  push(tg | 64'h2);
        @(negedge clk);
        ev_valid = 1'b0;
        if (xl) begin
            cmp({rq, " ready low"}, DW'(ev_ready), 0);
            @(negedge clk);
        end
        cmp({rq, " ready high"}, DW'(ev_ready), 1);
        drain(rq);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        cmp("R1 ptr", DW'(wr_ptr), 0);
        cmp("R1 ready", DW'(ev_ready), 1);
        foreach (mem_m[i]) begin
            rd_idx = AW'(i);
            #1 cmp("R1 entry", rd_data, 0);
        end
        send(5'h08, 64'h1000, 64'h0, "R1 mask cleared");

        set_ctl(1'b1, 2'd0);
        send(5'h08, 64'h2000, 64'h0, "R3 other");
        send(5'h01, 64'h2004, 64'h0, "R3 call");
        send(5'h04, 64'h2008, 64'h0, "R3 cond");
        send(5'h00, 64'h200C, 64'h0, "R7 zero type");
        send(5'h12, 64'h2010, 64'hABC0, "R8 indirect pair");

        set_ctl(1'b1, 2'd1);
        send(5'h04, 64'h3000, 64'h0, "R4 cond rejected");
        send(5'h08, 64'h3004, 64'h0, "R4 other rejected");
        send(5'h01, 64'h3008, 64'h0, "R4 call");
        send(5'h11, 64'h300C, 64'hF00D_0001, "R4 R8 call pair");

        set_ctl(1'b1, 2'd2);
        send(5'h11, 64'h4000, 64'h0, "R5 call rejected");
        send(5'h12, 64'h4004, 64'h5550, "R5 indirect pair");

        set_ctl(1'b1, 2'd3);
        send(5'h14, 64'h5000, 64'h7774, "R6 cond pair");
        send(5'h01, 64'h5004, 64'h0, "R6 call rejected");
        send(5'h08, 64'h5008, 64'h0, "R6 other rejected");

        set_ctl(1'b0, 2'd0);
        send(5'h1F, 64'h6000, 64'h1, "R2 disabled");
        set_ctl(1'b0, 2'd2);
        send(5'h02, 64'h6004, 64'h1, "R2 disabled mode2");

        // R11: control write alongside an event uses the old (empty) mask
        @(negedge clk);
        ctl_wr = 1'b1; ctl_enable = 1'b1; ctl_mode = 2'd0;
        ev_valid = 1'b1; ev_kind = 5'h08; ev_pc = 64'h7000;
        @(negedge clk);
        ctl_wr = 1'b0; ev_valid = 1'b0;
        cmp("R11 old mask", DW'(wr_ptr), DW'(ptr_m));
        mask_m = 5'h1F;
        send(5'h08, 64'h7004, 64'h0, "R11 new mask");

        // R10: same-cycle read returns old contents
        @(negedge clk);
        rd_idx = AW'(ptr_m);
        ev_valid = 1'b1; ev_kind = 5'h01; ev_pc = 64'h8000;
        #1 cmp("R10 old value", rd_data, mem_m[ptr_m]);
        @(negedge clk);
        ev_valid = 1'b0;
        push(64'h8000);
        drain("R10 new value");

        // R9: wrap past the last entry
        while (ptr_m != 0) send(5'h08, 64'h9000 + DW'(ptr_m), 64'h0, "R9 fill");
        send(5'h08, 64'hA000, 64'h0, "R9 wrap overwrite");
        cmp("R9 ptr after wrap", DW'(wr_ptr), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule